// File: doc/BRIEF.md
# Multi-Mode GPIO Controller with Grouped Interrupts

A register-mapped general-purpose I/O block for up to 64 pads. Every pin owns one 32-bit configuration word. That word sets the pin's direction and interrupt-sensing mode in a single 3-bit field. It also holds the output data bit, an input gate, a 2-bit alternate-function code that is passed straight out, and the number of the interrupt group (one of eight) that the pin reports to.

Pad inputs are resynchronised and then gated by the pin's input enable. The result feeds a per-pin detector for high level, low level, rising edge, falling edge or either edge. A detected event latches a sticky bit in the status word of the pin's chosen group. Software clears a status bit by writing 1 to it. Each group drives one interrupt line, which is the OR of that group's status bits.

Software sees all of this through a single-cycle request bus. A read returns its data on the cycle after the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The configuration word of pin p is at byte address 4·p. Its layout is: group at [18:16], input enable at [9], function code at [6:5], mode at [3:1], data at [0]; all other bits read 0. A read request returns its data on `rdata_o` in the following cycle, and `rdata_o` is 0 in any cycle that does not follow a read request.
- R2: In mode 1 (output), bit 0 of the pin word drives `gpio_o[p]` and reads back as written. `gpio_o` changes only after a bus write.
- R3: In every mode other than 1, bit 0 of the pin word reads the pad level. The pad passes through a two-flop synchroniser, so a change becomes visible within three cycles.
- R4: `gpio_oe_o[p]` is 1 only when the pin's mode is 1 and its function code is 0.
- R5: `func_o[2p+1:2p]` always shows the pin's function code.
- R6: While input enable (bit 9) is 0, the sampled pad reads as 0 and the pin raises no interrupt event.
- R7: Mode codes: 2 senses a high level, 3 a low level, 4 a rising edge, 5 a falling edge and 6 either edge. Modes 0, 1 and 7 raise no events.
- R8: An event of pin p sets bit p mod 32 of the status word at byte address 0x800 + 64·g + 4·(p div 32), where g is the pin's group. Status words of other groups are not touched.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When an event arrives in the same cycle as the clear, the event wins, so a level condition that still holds keeps the bit set.
- R10: `irq_o[g]` is the OR of all status bits of group g.
- R11: Reads of pin indices at or above NUM_PINS, of status words past the pin count, of unaligned addresses or of unmapped addresses return 0. Writes to them have no effect.
- R12: After reset, every pin word reads 0 with the pad low, all status bits are 0, and `gpio_o`, `gpio_oe_o`, `func_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| gpio_i | input | NUM_PINS | Pad input levels |
| gpio_o | output | NUM_PINS | Pad output levels |
| gpio_oe_o | output | NUM_PINS | Pad output enables |
| func_o | output | 2·NUM_PINS | Per-pin function code |
| irq_o | output | 8 | Per-group interrupt lines |

## Verification
Three cases are hard to reach from the ports:
- a pin numbered above 31 whose events must land in the second status word of a group other than 0;
- a clear that coincides with a persisting level condition;
- an input enable that hides a pad which is high.

Directed sequences reach each of these. One pin in the upper word is moved to group 5 and stepped through each sensing mode. Before every observation the bench clears the status word and waits out the synchroniser. The pin word, the status words of both groups and `irq_o` are then read back. A random phase first writes arbitrary configuration words, some of them to pins that do not exist, and compares each read-back and the pad-side outputs with a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned N_GROUPS  = 8;
  localparam int unsigned GRP_W     = 3;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned MAX_PINS  = 64;
  localparam logic [2:0]  STAT_PAGE = 3'b100;  // addr[11:9] of 0x800..0x9FF

  typedef enum logic [2:0] {
    MODE_IN     = 3'd0,
    MODE_OUT    = 3'd1,
    MODE_LVL_HI = 3'd2,
    MODE_LVL_LO = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_BOTH   = 3'd6,
    MODE_OFF    = 3'd7
  } pin_mode_e;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic             ien;
    logic [1:0]       func;
    pin_mode_e        mode;
    logic             dout;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(logic [31:0] w);
    pin_cfg_t c;
    c.grp  = w[18:16];
    c.ien  = w[9];
    c.func = w[6:5];
    c.mode = pin_mode_e'(w[3:1]);
    c.dout = w[0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(pin_cfg_t c, logic bit0);
    return {13'd0, c.grp, 6'd0, c.ien, 2'd0, c.func, 1'b0, c.mode, bit0};
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      ien_i,
  input  logic      raw_i,
  output logic      lvl_o,
  output logic      evt_o
);
  logic prev_q, hit;

  assign lvl_o = raw_i & ien_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;
  end

  always_comb begin
    unique case (mode_i)
      MODE_LVL_HI: hit = lvl_o;
      MODE_LVL_LO: hit = ~lvl_o;
      MODE_RISE:   hit = lvl_o & ~prev_q;
      MODE_FALL:   hit = ~lvl_o & prev_q;
      MODE_BOTH:   hit = lvl_o ^ prev_q;
      default:     hit = 1'b0;
    endcase
  end

  // disabling the input must not create a falling edge
  assign evt_o = hit & ien_i;
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PINS-1:0]                 evt_i,
  input  logic [NUM_PINS-1:0][GRP_W-1:0]      grp_i,
  input  logic                                clr_i,
  input  logic [GRP_W-1:0]                    clr_grp_i,
  input  logic [3:0]                          clr_word_i,
  input  logic [31:0]                         clr_mask_i,
  output logic [N_GROUPS*NUM_PINS-1:0]        stat_o,
  output logic [N_GROUPS-1:0]                 irq_o
);
  logic [N_GROUPS*NUM_PINS-1:0] stat_q, stat_d;

  always_comb begin
    for (int g = 0; g < N_GROUPS; g++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        logic set_b, clr_b;
        set_b = evt_i[p] && (grp_i[p] == GRP_W'(g));
        clr_b = clr_i && (clr_grp_i == GRP_W'(g)) &&
                (clr_word_i == 4'(p / 32)) && clr_mask_i[p % 32];
        // set wins over a coincident clear
        stat_d[g*NUM_PINS+p] = (stat_q[g*NUM_PINS+p] & ~clr_b) | set_b;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_irq
    assign irq_o[g] = |stat_q[g*NUM_PINS +: NUM_PINS];
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   gpio_i,
  output logic [NUM_PINS-1:0]   gpio_o,
  output logic [NUM_PINS-1:0]   gpio_oe_o,
  output logic [2*NUM_PINS-1:0] func_o,
  output logic [N_GROUPS-1:0]   irq_o
);
  localparam int unsigned NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int unsigned IDX_W     = $clog2(MAX_PINS);

  pin_cfg_t                     cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0]          pad_sync, pad_lvl, pin_evt, ien_vec;
  logic [NUM_PINS-1:0][GRP_W-1:0] grp_vec;
  logic [N_GROUPS*NUM_PINS-1:0] stat_flat;

  // address decode
  logic             aligned, pin_hit, stat_hit, stat_clr;
  logic [IDX_W-1:0] pin_idx;
  logic [GRP_W-1:0] sel_grp;
  logic [3:0]       sel_word;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign pin_idx  = addr_i[7:2];
  assign sel_grp  = addr_i[8:6];
  assign sel_word = addr_i[5:2];
  assign pin_hit  = aligned && (addr_i[ADDR_W-1:8] == '0) &&
                    ({1'b0, pin_idx} < (IDX_W+1)'(NUM_PINS));
  assign stat_hit = aligned && (addr_i[ADDR_W-1:9] == STAT_PAGE) &&
                    ({1'b0, sel_word} < 5'(NUM_WORDS));
  assign stat_clr = req_i && we_i && stat_hit;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pad_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[p] <= '0;
      else if (req_i && we_i && pin_hit && (pin_idx == IDX_W'(p)))
        cfg_q[p] <= unpack_cfg(wdata_i);
    end

    gpio_pin_event u_evt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(cfg_q[p].mode),
      .ien_i (cfg_q[p].ien),
      .raw_i (pad_sync[p]),
      .lvl_o (pad_lvl[p]),
      .evt_o (pin_evt[p])
    );

    assign ien_vec[p]       = cfg_q[p].ien;
    assign grp_vec[p]       = cfg_q[p].grp;
    assign gpio_o[p]        = cfg_q[p].dout;
    assign gpio_oe_o[p]     = (cfg_q[p].mode == MODE_OUT) && (cfg_q[p].func == 2'b00);
    assign func_o[2*p +: 2] = cfg_q[p].func;
  end

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (pin_evt),
    .grp_i     (grp_vec),
    .clr_i     (stat_clr),
    .clr_grp_i (sel_grp),
    .clr_word_i(sel_word),
    .clr_mask_i(wdata_i),
    .stat_o    (stat_flat),
    .irq_o     (irq_o)
  );

  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (pin_hit) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (pin_idx == IDX_W'(p))
          rd_val = pack_cfg(cfg_q[p],
                            (cfg_q[p].mode == MODE_OUT) ? cfg_q[p].dout : pad_lvl[p]);
      end
    end else if (stat_hit) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (sel_word == 4'(p / 32))
          rd_val[p % 32] = stat_flat[int'(sel_grp)*NUM_PINS + p];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (req_i && !we_i)    rdata_o <= rd_val;
    else                        rdata_o <= '0;
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         we_i,
  input logic [31:0]                  rdata_o,
  input logic [NUM_PINS-1:0]          gpio_o,
  input logic [NUM_PINS-1:0]          gpio_oe_o,
  input logic [2*NUM_PINS-1:0]        func_o,
  input logic [N_GROUPS-1:0]          irq_o,
  input logic [NUM_PINS-1:0]          ien_vec,
  input logic [N_GROUPS*NUM_PINS-1:0] stat_flat
);
  logic [NUM_PINS-1:0] pin_pending;

  always_comb begin
    pin_pending = '0;
    for (int g = 0; g < N_GROUPS; g++)
      pin_pending = pin_pending | stat_flat[g*NUM_PINS +: NUM_PINS];
  end

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> (rdata_o == '0)); // R1

  AST_DOUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(gpio_o)); // R2

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    AST_OE_NEEDS_FUNC0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gpio_oe_o[p] |-> (func_o[2*p +: 2] == 2'b00)); // R4

    AST_IEN_BLOCKS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!ien_vec[p] && !pin_pending[p]) |-> !pin_pending[p]); // R6
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp_chk
    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(irq_o[g]) && !$past(req_i && we_i)) |-> irq_o[g]); // R10
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .gpio_o   (gpio_o),
  .gpio_oe_o(gpio_oe_o),
  .func_o   (func_o),
  .irq_o    (irq_o),
  .ien_vec  (ien_vec),
  .stat_flat(stat_flat)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int unsigned NP       = 40;
  localparam int unsigned CLK_PER  = 10;
  localparam int unsigned WD_LIMIT = 100000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0, rdata;
  logic [NP-1:0]   pad = '0, gpio_o, gpio_oe;
  logic [2*NP-1:0] func_o;
  logic [7:0]      irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // bench model of the pin words
  logic [2:0] m_grp [NP];
  logic       m_ien [NP];
  logic [1:0] m_func[NP];
  logic [2:0] m_mode[NP];
  logic       m_dout[NP];

  always #(CLK_PER/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(pad), .gpio_o(gpio_o),
    .gpio_oe_o(gpio_oe), .func_o(func_o), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(logic [2:0] g, logic ien, logic [1:0] f,
                                     logic [2:0] m, logic d);
    return {13'd0, g, 6'd0, ien, 2'd0, f, 1'b0, m, d};
  endfunction

  function automatic logic [31:0] exp_pin(int p);
    logic b0;
    b0 = (m_mode[p] == 3'd1) ? m_dout[p] : (pad[p] & m_ien[p]);
    return mk(m_grp[p], m_ien[p], m_func[p], m_mode[p], b0);
  endfunction

  function automatic logic [11:0] stat_addr(int g, int p);
    return 12'(32'h800 + g * 64 + (p / 32) * 4);
  endfunction

  task automatic cfg_pin(input int p, input logic [31:0] d);
    wr(12'(p * 4), d);
    if (p < NP) begin
      m_grp[p] = d[18:16]; m_ien[p] = d[9]; m_func[p] = d[6:5];
      m_mode[p] = d[3:1]; m_dout[p] = d[0];
    end
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'h5eed_0a17));
    for (int p = 0; p < NP; p++) begin
      m_grp[p] = '0; m_ien[p] = 1'b0; m_func[p] = '0; m_mode[p] = '0; m_dout[p] = 1'b0;
    end
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R12 reset state
    rd(12'h000, r);            chk("R12 pin0 word", 64'(r), 64'h0);
    rd(12'(39*4), r);          chk("R12 pin39 word", 64'(r), 64'h0);
    rd(12'h800, r);            chk("R12 status g0w0", 64'(r), 64'h0);
    chk("R12 oe", 64'(gpio_oe), 64'h0);
    chk("R12 gpio_o", 64'(gpio_o), 64'h0);
    chk("R12 func_o", 64'(func_o), 64'h0);
    chk("R12 irq", 64'(irq), 64'h0);

    // random config phase: R1 R2 R3 R4 R5 R11
    pad = {$urandom, $urandom};
    idle(4);
    for (int i = 0; i < 300; i++) begin
      int p;
      logic [31:0] d;
      p = $urandom_range(0, 47);
      d = $urandom;
      cfg_pin(p, d);
      p = $urandom_range(0, NP - 1);
      rd(12'(p * 4), r);
      chk("R1 random pin readback", 64'(r), 64'(exp_pin(p)));
      chk("R4 oe vs model", 64'(gpio_oe[p]),
          64'((m_mode[p] == 3'd1) && (m_func[p] == 2'd0)));
      chk("R5 func_o vs model", 64'(func_o[2*p +: 2]), 64'(m_func[p]));
      chk("R2 gpio_o vs model", 64'(gpio_o[p]), 64'(m_dout[p]));
    end

    // quiet everything, clear all status
    for (int p = 0; p < NP; p++) cfg_pin(p, 32'h0);
    pad = '0;
    idle(5);
    for (int g = 0; g < 8; g++)
      for (int w = 0; w < 2; w++) wr(12'(32'h800 + g * 64 + w * 4), 32'hffff_ffff);
    chk("R10 irq idle", 64'(irq), 64'h0);

    // R2 output mode readback
    cfg_pin(12, mk(3'd0, 1'b0, 2'd0, 3'd1, 1'b1));
    rd(12'(12*4), r);
    chk("R2 out bit0 readback", 64'(r[0]), 64'h1);
    chk("R2 gpio_o driven", 64'(gpio_o[12]), 64'h1);

    // R4 R5 function code hands pin away
    cfg_pin(7, mk(3'd0, 1'b0, 2'd2, 3'd1, 1'b1));
    chk("R4 oe with func 2", 64'(gpio_oe[7]), 64'h0);
    chk("R5 func_o pin7", 64'(func_o[15:14]), 64'h2);
    cfg_pin(7, mk(3'd0, 1'b0, 2'd0, 3'd1, 1'b0));
    chk("R4 oe with func 0", 64'(gpio_oe[7]), 64'h1);

    // R3 synchronised input read
    cfg_pin(10, mk(3'd0, 1'b1, 2'd0, 3'd0, 1'b0));
    pad[10] = 1'b1;
    idle(3);
    rd(12'(10*4), r);
    chk("R3 input sampled", 64'(r[0]), 64'h1);

    // R7 R8 rising edge on pin 35, group 5, upper word
    cfg_pin(35, mk(3'd5, 1'b1, 2'd0, 3'd4, 1'b0));
    idle(5);
    wr(stat_addr(5, 35), 32'hffff_ffff);
    rd(stat_addr(5, 35), r);   chk("R7 rise idle", 64'(r), 64'h0);
    pad[35] = 1'b1;
    idle(5);
    rd(stat_addr(5, 35), r);   chk("R8 rise sets g5w1 bit3", 64'(r), 64'h8);
    rd(stat_addr(0, 35), r);   chk("R8 other group untouched", 64'(r), 64'h0);
    rd(stat_addr(5, 0), r);    chk("R8 other word untouched", 64'(r), 64'h0);
    chk("R10 irq group5", 64'(irq), 64'h20);
    wr(stat_addr(5, 35), 32'h0);
    rd(stat_addr(5, 35), r);   chk("R9 write 0 keeps", 64'(r), 64'h8);
    wr(stat_addr(5, 35), 32'h8);
    rd(stat_addr(5, 35), r);   chk("R9 write 1 clears", 64'(r), 64'h0);
    chk("R10 irq cleared", 64'(irq), 64'h0);
    pad[35] = 1'b0;
    idle(5);
    rd(stat_addr(5, 35), r);   chk("R7 fall ignored in rise mode", 64'(r), 64'h0);

    // R9 level low re-asserts
    cfg_pin(35, mk(3'd5, 1'b1, 2'd0, 3'd3, 1'b0));
    idle(4);
    rd(stat_addr(5, 35), r);   chk("R7 level low sets", 64'(r), 64'h8);
    wr(stat_addr(5, 35), 32'h8);
    rd(stat_addr(5, 35), r);   chk("R9 level re-set", 64'(r), 64'h8);
    pad[35] = 1'b1;
    idle(5);
    wr(stat_addr(5, 35), 32'h8);
    rd(stat_addr(5, 35), r);   chk("R7 level low gone", 64'(r), 64'h0);

    // R7 mode off ignores toggling
    cfg_pin(35, mk(3'd5, 1'b1, 2'd0, 3'd7, 1'b0));
    wr(stat_addr(5, 35), 32'hffff_ffff);
    pad[35] = 1'b0; idle(4); pad[35] = 1'b1; idle(5);
    rd(stat_addr(5, 35), r);   chk("R7 mode off silent", 64'(r), 64'h0);

    // R6 input gate hides high level
    cfg_pin(35, mk(3'd5, 1'b0, 2'd0, 3'd2, 1'b0));
    wr(stat_addr(5, 35), 32'hffff_ffff);
    idle(4);
    rd(stat_addr(5, 35), r);   chk("R6 no event with ien 0", 64'(r), 64'h0);
    rd(12'(35*4), r);          chk("R6 gated read 0", 64'(r[0]), 64'h0);
    cfg_pin(35, mk(3'd5, 1'b1, 2'd0, 3'd2, 1'b0));
    idle(3);
    rd(12'(35*4), r);          chk("R3 pad high visible", 64'(r[0]), 64'h1);
    rd(stat_addr(5, 35), r);   chk("R7 level high sets", 64'(r), 64'h8);

    // R7 either edge
    cfg_pin(35, mk(3'd5, 1'b1, 2'd0, 3'd6, 1'b0));
    idle(3);
    wr(stat_addr(5, 35), 32'h8);
    pad[35] = 1'b0; idle(5);
    rd(stat_addr(5, 35), r);   chk("R7 both: fall", 64'(r), 64'h8);
    wr(stat_addr(5, 35), 32'h8);
    pad[35] = 1'b1; idle(5);
    rd(stat_addr(5, 35), r);   chk("R7 both: rise", 64'(r), 64'h8);
    wr(stat_addr(5, 35), 32'h8);

    // R7 falling edge, pin 2 in group 0 lower word
    pad[2] = 1'b1;
    cfg_pin(2, mk(3'd0, 1'b1, 2'd0, 3'd5, 1'b0));
    idle(5);
    wr(12'h800, 32'hffff_ffff);
    pad[2] = 1'b0; idle(5);
    rd(12'h800, r);            chk("R7 fall sets g0w0 bit2", 64'(r), 64'h4);
    chk("R10 irq group0", 64'(irq), 64'h01);

    // R11 unmapped and out of range
    rd(12'(45*4), r);          chk("R11 pin beyond count", 64'(r), 64'h0);
    cfg_pin(45, 32'hffff_ffff);
    rd(12'(5*4), r);           chk("R11 no alias write", 64'(r), 64'(exp_pin(5)));
    wr(12'h300, 32'hffff_ffff);
    rd(12'h300, r);            chk("R11 unmapped read", 64'(r), 64'h0);
    rd(12'h801, r);            chk("R11 unaligned read", 64'(r), 64'h0);
    rd(12'h808, r);            chk("R11 status word past count", 64'(r), 64'h0);
    wr(12'h801, 32'hffff_ffff);
    rd(12'h800, r);            chk("R11 unaligned write no clear", 64'(r), 64'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule